// File: doc/BRIEF.md
# Relative Branch and Loop-Counter Unit

This unit resolves the short relative control-flow instructions of a processor core with a 24-bit address space. Once the operand byte has been fetched, the sequencer pulses `start` and presents the kind of branch, the signed 8-bit offset, the address of the instruction that follows the branch, the current zero flag and the current B register. The unit decides whether the branch is taken. It forms the new program counter by adding the sign-extended offset to the following-instruction address, modulo 2^24. For the loop kind it also computes the decremented B value.

Results appear on the outputs at the clock edge that accepts `start` and hold until the next accepted `start`. The unit stays busy for as many cycles as the instruction costs. It pulses `done` for one cycle when that cost has elapsed, so the sequencer can retire the instruction at the right time. No flag is produced: these instructions leave every flag as it was. Fetching the offset byte from memory is the job of the surrounding core.

Top module: `relbr_unit`

## Requirements
- R1: After reset, `busy`, `done`, `taken`, `pc_out`, `b_out` and `cycles` are all zero.
- R2: `op_kind` encodes the branch kind: 2'b00 always branches, 2'b01 branches when `zflag` is 0, 2'b10 branches when `zflag` is 1, and 2'b11 is the loop kind. `taken` reports the decision.
- R3: When taken, `pc_out` equals `next_pc` plus `disp` sign-extended to 24 bits, wrapping modulo 2^24. When not taken, `pc_out` equals `next_pc`.
- R4: For the loop kind, `b_out` equals `b_in` minus one modulo 256, and the branch is taken exactly when that new value is non-zero. A `b_in` of 0x01 is not taken, and a `b_in` of 0x00 gives 0xFF and is taken.
- R5: For the three non-loop kinds, `b_out` equals `b_in` unchanged.
- R6: `cycles` reports the cost: 3 for kind 00; 3 taken or 2 not taken for kinds 01 and 10; 4 taken or 2 not taken for kind 11.
- R7: If `start` is accepted at clock edge E, then `busy` is high from E until edge E+N, and `done` is high for exactly the one cycle after edge E+N, where N is the reported cost.
- R8: `start` is accepted only while `busy` is low. A `start` raised while busy changes no output and does not alter the `done` timing.
- R9: A `start` raised in the cycle where `done` is high is accepted, so instructions can issue back to back with no idle cycle.
- R10: For kinds 00 and 11, `zflag` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a branch instruction |
| op_kind | input | 2 | Branch kind (see R2) |
| disp | input | 8 | Signed relative offset |
| next_pc | input | 24 | Address of the following instruction |
| zflag | input | 1 | Current zero flag |
| b_in | input | 8 | Current B register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| pc_out | output | 24 | New program counter |
| b_out | output | 8 | New B register value |
| cycles | output | 3 | Cycle cost of the instruction |

## Verification
The completion of one instruction and the acceptance of the next can fall in the same cycle. While `done` is high, `busy` is already low, so a `start` raised then must be taken up. The bench provokes this by raising `start` with fresh operands in the very cycle it sees the `done` pulse. Its clock-by-clock reference model must then show no idle cycle, the new results at the following edge, and a second `done` exactly the new cost later. A `start` raised while still busy must leave the earlier results and their `done` timing untouched.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

    typedef enum logic [1:0] {
        BR_ALWAYS = 2'b00,
        BR_IF_NZ  = 2'b01,
        BR_IF_Z   = 2'b10,
        BR_LOOP   = 2'b11
    } br_kind_e;

    localparam int CYC_SHORT = 2;
    localparam int CYC_MID   = 3;
    localparam int CYC_LONG  = 4;

endpackage

// File: rtl/relbr_decide.sv
module relbr_decide
    import relbr_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int CNT_W = 3
) (
    input  br_kind_e         kind,
    input  logic             zflag,
    input  logic [REG_W-1:0] b_in,
    output logic             taken,
    output logic [REG_W-1:0] b_next,
    output logic [CNT_W-1:0] cost
);

    logic [REG_W-1:0] b_dec;

    always_comb begin
        b_dec  = b_in - REG_W'(1);
        b_next = b_in;
        taken  = 1'b0;
        cost   = CNT_W'(CYC_SHORT);
        unique case (kind)
            BR_ALWAYS: begin
                taken = 1'b1;
                cost  = CNT_W'(CYC_MID);
            end
            BR_IF_NZ: begin
                taken = ~zflag;
                cost  = zflag ? CNT_W'(CYC_SHORT) : CNT_W'(CYC_MID);
            end
            BR_IF_Z: begin
                taken = zflag;
                cost  = zflag ? CNT_W'(CYC_MID) : CNT_W'(CYC_SHORT);
            end
            BR_LOOP: begin
                b_next = b_dec;
                taken  = (b_dec != '0);
                cost   = (b_dec != '0) ? CNT_W'(CYC_LONG) : CNT_W'(CYC_SHORT);
            end
            default: begin
                taken = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/relbr_target.sv
module relbr_target #(
    parameter int PC_W   = 24,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic              taken,
    output logic [PC_W-1:0]   target
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] offset;

    always_comb begin
        offset = {{EXT_W{disp[DISP_W-1]}}, disp};
        target = taken ? (base + offset) : base;
    end

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
    import relbr_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int DISP_W = 8,
    parameter int REG_W  = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              zflag,
    input  logic [REG_W-1:0]  b_in,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   pc_out,
    output logic [REG_W-1:0]  b_out,
    output logic [CNT_W-1:0]  cycles
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] left;
        logic             taken;
        logic [PC_W-1:0]  pc;
        logic [REG_W-1:0] b;
        logic [CNT_W-1:0] cost;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic             dec_taken;
    logic [REG_W-1:0] dec_b;
    logic [CNT_W-1:0] dec_cost;
    logic [PC_W-1:0]  tgt_pc;

    relbr_decide #(
        .REG_W (REG_W),
        .CNT_W (CNT_W)
    ) u_decide (
        .kind   (br_kind_e'(op_kind)),
        .zflag  (zflag),
        .b_in   (b_in),
        .taken  (dec_taken),
        .b_next (dec_b),
        .cost   (dec_cost)
    );

    relbr_target #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W)
    ) u_target (
        .base   (next_pc),
        .disp   (disp),
        .taken  (dec_taken),
        .target (tgt_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy && start) begin
            st_d.busy  = 1'b1;
            st_d.left  = dec_cost - CNT_W'(1);
            st_d.taken = dec_taken;
            st_d.pc    = tgt_pc;
            st_d.b     = dec_b;
            st_d.cost  = dec_cost;
        end else if (st_q.busy) begin
            if (st_q.left == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.left = st_q.left - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign taken  = st_q.taken;
    assign pc_out = st_q.pc;
    assign b_out  = st_q.b;
    assign cycles = st_q.cost;

endmodule

// File: rtl/relbr_unit_chk.sv
module relbr_unit_chk #(
    parameter int REG_W = 8,
    parameter int PC_W  = 24,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       op_kind,
    input logic [REG_W-1:0] b_in,
    input logic             busy,
    input logic             done,
    input logic             taken,
    input logic [PC_W-1:0]  pc_out,
    input logic [REG_W-1:0] b_out,
    input logic [CNT_W-1:0] cycles
);

    logic accept;
    assign accept = start && !busy;

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_holds_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pc_out) && $stable(b_out));

    p_always_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_kind == 2'b00) |=> (taken && cycles == CNT_W'(3)));

    p_loop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_kind == 2'b11) |=> (b_out == $past(b_in) - REG_W'(1)));

    p_b_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_kind != 2'b11) |=> (b_out == $past(b_in)));

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

endmodule

bind relbr_unit relbr_unit_chk #(
    .REG_W (REG_W),
    .PC_W  (PC_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_kind (op_kind),
    .b_in    (b_in),
    .busy    (busy),
    .done    (done),
    .taken   (taken),
    .pc_out  (pc_out),
    .b_out   (b_out),
    .cycles  (cycles)
);

// File: tb/sim_relbr_unit.sv
`timescale 1ns/1ps
module sim_relbr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [7:0]  disp = 8'h00;
    logic [23:0] next_pc = 24'h0;
    logic        zflag = 1'b0;
    logic [7:0]  b_in = 8'h00;
    logic        busy, done, taken;
    logic [23:0] pc_out;
    logic [7:0]  b_out;
    logic [2:0]  cycles;

    int n_run = 0;
    int n_fail = 0;
    string ctx = "R1 reset";

    // reference model state
    int m_busy = 0, m_done = 0, m_left = 0, m_taken = 0, m_cost = 0;
    int m_pc = 0, m_b = 0;

    always #2 clk = ~clk;

    relbr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .disp(disp), .next_pc(next_pc), .zflag(zflag), .b_in(b_in),
        .busy(busy), .done(done), .taken(taken), .pc_out(pc_out),
        .b_out(b_out), .cycles(cycles)
    );

    task automatic chk(input string what, input int act, input int exp, input string req);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, ctx, what, act, exp);
        end
    endtask

    task automatic model_step();
        int sd, nb, tk, cst;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; m_taken = 0;
            m_cost = 0; m_pc = 0; m_b = 0;
        end else if (start && m_busy == 0) begin
            sd = (disp >= 128) ? int'(disp) - 256 : int'(disp);
            nb = int'(b_in);
            case (op_kind)
                2'b00: begin tk = 1; cst = 3; end
                2'b01: begin tk = (zflag == 1'b0); cst = tk ? 3 : 2; end
                2'b10: begin tk = (zflag == 1'b1); cst = tk ? 3 : 2; end
                default: begin
                    nb = (int'(b_in) + 255) % 256;
                    tk = (nb != 0);
                    cst = tk ? 4 : 2;
                end
            endcase
            m_taken = tk; m_cost = cst; m_b = nb;
            m_pc = tk ? ((int'(next_pc) + sd + 16777216) % 16777216) : int'(next_pc);
            m_busy = 1; m_left = cst - 1; m_done = 0;
        end else if (m_busy != 0) begin
            if (m_left == 0) begin m_busy = 0; m_done = 1; end
            else begin m_left--; m_done = 0; end
        end else begin
            m_done = 0;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        chk("busy",   int'(busy),   m_busy,  "R7");
        chk("done",   int'(done),   m_done,  "R7");
        chk("taken",  int'(taken),  m_taken, "R2");
        chk("pc_out", int'(pc_out), m_pc,    "R3");
        chk("b_out",  int'(b_out),  m_b,     "R4/R5");
        chk("cycles", int'(cycles), m_cost,  "R6");
    endtask

    task automatic set_ops(input logic [1:0] k, input logic [7:0] d,
                           input logic [23:0] np, input logic z, input logic [7:0] b);
        op_kind = k; disp = d; next_pc = np; zflag = z; b_in = b;
    endtask

    // issue one instruction and run it to its done pulse
    task automatic run_op(input string c, input logic [1:0] k, input logic [7:0] d,
                          input logic [23:0] np, input logic z, input logic [7:0] b);
        ctx = c;
        set_ops(k, d, np, z, b);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 8 && m_done == 0; i++) tick();
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        ctx = "R1 after reset";
        tick();

        run_op("R2 R3 always fwd",          2'b00, 8'h10, 24'h001000, 1'b0, 8'h33);
        tick();
        run_op("R2 R3 always back",         2'b00, 8'hF0, 24'h001000, 1'b1, 8'h33);
        tick();
        run_op("R3 wrap up",                2'b00, 8'h10, 24'hFFFFF8, 1'b0, 8'h01);
        tick();
        run_op("R3 wrap down",              2'b00, 8'h80, 24'h000004, 1'b0, 8'h01);
        tick();
        run_op("R2 R6 nz taken",            2'b01, 8'h05, 24'h000200, 1'b0, 8'h10);
        tick();
        run_op("R2 R6 nz not taken",        2'b01, 8'h05, 24'h000200, 1'b1, 8'h10);
        tick();
        run_op("R2 R6 z taken",             2'b10, 8'hFE, 24'h000200, 1'b1, 8'h10);
        tick();
        run_op("R2 R6 z not taken",         2'b10, 8'hFE, 24'h000200, 1'b0, 8'h10);
        tick();
        run_op("R4 loop b=5",               2'b11, 8'hFC, 24'h000300, 1'b0, 8'h05);
        tick();
        run_op("R4 loop b=1",               2'b11, 8'hFC, 24'h000300, 1'b0, 8'h01);
        tick();
        run_op("R4 loop b=0 wraps",         2'b11, 8'h7F, 24'h000300, 1'b1, 8'h00);
        tick();
        run_op("R10 loop zflag=1",          2'b11, 8'h02, 24'h000400, 1'b1, 8'h09);
        tick();
        run_op("R10 always zflag=1",        2'b00, 8'h02, 24'h000400, 1'b1, 8'h09);
        tick();

        // R8: start raised while busy must be ignored
        ctx = "R8 start while busy";
        set_ops(2'b11, 8'h20, 24'h000500, 1'b0, 8'h40);
        start = 1'b1;
        tick();
        set_ops(2'b00, 8'h77, 24'h00ABCD, 1'b1, 8'hAA);
        tick();
        tick();
        start = 1'b0;
        for (int i = 0; i < 8 && m_done == 0; i++) tick();

        // R9: back-to-back issue in the done cycle
        ctx = "R9 back to back";
        set_ops(2'b10, 8'h08, 24'h000600, 1'b1, 8'h02);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 8 && m_done == 0; i++) tick();
        set_ops(2'b11, 8'hF8, 24'h000700, 1'b0, 8'h02);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 8 && m_done == 0; i++) tick();
        set_ops(2'b01, 8'h01, 24'h000800, 1'b1, 8'h03);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 8 && m_done == 0; i++) tick();
        tick(); tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule